// File: doc/BRIEF.md
# Dual-Limit Event Timer

A 16-bit event timer that advances a count on each qualified event and wraps it to zero when the incremented value matches the active limit. The limit value itself is never held in the count. Two limit registers are available. In single-limit mode only the primary limit is used, and the waveform pin drops Low for one clock after each wrap. In dual-limit mode the timer hands control back and forth between the primary and the alternate limit on every wrap. The pin level then shows which limit is in charge, so the two limit values set the duty cycle of the resulting waveform.

The timer logic acts only in one service slot out of every four clocks, so the fastest event rate is a quarter of the clock. Events come either from every service slot (internal source) or from rising edges on an external input. That input passes through a two-stage synchronizer, and each rising edge is held as pending until the next slot consumes it. Software programs the timer through a small register bus with a registered read port. The count can be read or overwritten at any time. A one-shot option stops the timer after its final limit.

Top module: `dl_event_timer`

## Requirements
- R1: After reset the control word, count and both limits read 0, and `wave_out` is High.
- R2: Register addresses are 0 control, 1 count, 2 primary limit, 3 alternate limit. A read strobe loads `bus_rdata` at the clock edge and the value is valid from that edge on. Control bits are bit0 run, bit1 dual-limit, bit2 continuous (0 = one-shot), bit3 external source, and bit4 a read-only flag that is 1 while the alternate limit is active. A count write takes effect even in a service slot, where it overrides the increment.
- R3: Each counted event adds one to the count. When the incremented value equals the active limit, the count becomes 0 instead. A limit of 0 therefore means 65536 events.
- R4: Events are processed only at service slots, every fourth clock. With the internal source selected and run set, every slot is one event.
- R5: In single-limit mode `wave_out` is Low for exactly one clock following each wrap and High otherwise.
- R6: In dual-limit mode each wrap swaps the active limit. `wave_out` is High while the primary limit is active and Low while the alternate limit is active.
- R7: Any write to the control register makes the primary limit active again (flag bit4 reads 0).
- R8: In one-shot mode the run bit clears itself at the wrap on the primary limit (single-limit mode) or on the alternate limit (dual-limit mode).
- R9: With the external source selected, each rising edge of `ext_evt` is counted exactly once, and its wrap shows on `wave_out` 3 to 6 clocks after the edge is applied.
- R10: With run clear the count does not change. External edges seen while stopped are discarded at the next slot and are not counted later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 16 | Write data |
| bus_rdata | output | 16 | Registered read data |
| ext_evt | input | 1 | Asynchronous external event input |
| wave_out | output | 1 | Registered waveform output |

## Verification
The hardest state to reach from the ports is the timing of an external edge against the service slot. The latency to the output depends on which of the four phases the synchronized edge lands in. The stimulus applies the edge at each of the four phase offsets, using a bench-side count of clock edges since reset, and measures the clocks to the output pulse in each case. Write-over-increment and the control-write flag clear are reached the same way: writes are timed so their edge is a service slot, or so they land while the alternate limit is known to be active.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] A_CTL = 2'd0;
  localparam logic [1:0] A_CNT = 2'd1;
  localparam logic [1:0] A_PRI = 2'd2;
  localparam logic [1:0] A_ALT = 2'd3;

  localparam int B_RUN  = 0;
  localparam int B_DUAL = 1;
  localparam int B_CONT = 2;
  localparam int B_EXT  = 3;
  localparam int B_ALT  = 4;

  typedef struct packed {
    logic ext;
    logic cont;
    logic dual;
    logic run;
  } ctl_t;
endpackage

// File: rtl/tmr_slot_gen.sv
module tmr_slot_gen #(
  parameter int SLOTS = 4
) (
  input  logic clk,
  input  logic rst,
  output logic svc_o
);
  localparam int PW = (SLOTS > 1) ? $clog2(SLOTS) : 1;
  localparam logic [PW-1:0] LAST = PW'(SLOTS - 1);

  logic [PW-1:0] phase_q;

  always_ff @(posedge clk) begin
    if (rst)                 phase_q <= '0;
    else if (phase_q == LAST) phase_q <= '0;
    else                     phase_q <= phase_q + 1'b1;
  end

  assign svc_o = (phase_q == LAST);
endmodule

// File: rtl/tmr_ext_sync.sv
module tmr_ext_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic svc,
  input  logic ext_i,
  output logic evt_o
);
  localparam int SW = STAGES + 1;

  logic [SW-1:0] sh_q;
  logic          rise;
  logic          pend_q;

  always_ff @(posedge clk) begin
    if (rst) sh_q <= '0;
    else     sh_q <= {sh_q[SW-2:0], ext_i};
  end

  assign rise = sh_q[STAGES-1] & ~sh_q[STAGES];

  always_ff @(posedge clk) begin
    if (rst)       pend_q <= 1'b0;
    else if (svc)  pend_q <= 1'b0;
    else if (rise) pend_q <= 1'b1;
  end

  assign evt_o = pend_q | rise;
endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         svc,
  input  logic         run,
  input  logic         dual,
  input  logic         cont,
  input  logic         evt,
  input  logic [W-1:0] lim_pri,
  input  logic [W-1:0] lim_alt,
  input  logic         cnt_we,
  input  logic [W-1:0] cnt_wd,
  input  logic         alt_clr,
  output logic [W-1:0] cnt_q,
  output logic         alt_q,
  output logic         wave_q,
  output logic         stop_o
);
  logic         tick;
  logic         hit;
  logic [W-1:0] inc;
  logic [W-1:0] lim;
  logic         alt_d;

  assign tick = svc & run & evt;
  assign inc  = cnt_q + 1'b1;
  assign lim  = alt_q ? lim_alt : lim_pri;
  assign hit  = tick && (inc == lim);

  always_comb begin
    alt_d = alt_q;
    if (alt_clr)         alt_d = 1'b0;
    else if (hit && dual) alt_d = ~alt_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      alt_q  <= 1'b0;
      wave_q <= 1'b1;
    end else begin
      if (cnt_we)    cnt_q <= cnt_wd;
      else if (hit)  cnt_q <= '0;
      else if (tick) cnt_q <= inc;
      alt_q  <= alt_d;
      wave_q <= dual ? ~alt_d : ~hit;
    end
  end

  assign stop_o = hit && !cont && (!dual || alt_q);
endmodule

// File: rtl/dl_event_timer.sv
module dl_event_timer #(
  parameter int W           = 16,
  parameter int SLOTS       = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         bus_sel,
  input  logic         bus_wr,
  input  logic [1:0]   bus_addr,
  input  logic [W-1:0] bus_wdata,
  output logic [W-1:0] bus_rdata,
  input  logic         ext_evt,
  output logic         wave_out
);
  import tmr_pkg::*;

  ctl_t         ctl_q;
  logic [W-1:0] pri_q;
  logic [W-1:0] alt_lim_q;
  logic [W-1:0] cnt_q;
  logic         alt_q;
  logic         wave_q;
  logic         svc;
  logic         ext_e;
  logic         evt;
  logic         stop;
  logic         ctl_we;
  logic         cnt_we;
  logic         rd_en;
  logic [W-1:0] rd_mux;

  assign ctl_we = bus_sel && bus_wr && (bus_addr == A_CTL);
  assign cnt_we = bus_sel && bus_wr && (bus_addr == A_CNT);
  assign rd_en  = bus_sel && !bus_wr;

  tmr_slot_gen #(.SLOTS(SLOTS)) i_slot (
    .clk(clk), .rst(rst), .svc_o(svc)
  );

  tmr_ext_sync #(.STAGES(SYNC_STAGES)) i_sync (
    .clk(clk), .rst(rst), .svc(svc), .ext_i(ext_evt), .evt_o(ext_e)
  );

  assign evt = ctl_q.ext ? ext_e : 1'b1;

  tmr_count_core #(.W(W)) i_core (
    .clk(clk), .rst(rst), .svc(svc), .run(ctl_q.run), .dual(ctl_q.dual),
    .cont(ctl_q.cont), .evt(evt), .lim_pri(pri_q), .lim_alt(alt_lim_q),
    .cnt_we(cnt_we), .cnt_wd(bus_wdata), .alt_clr(ctl_we),
    .cnt_q(cnt_q), .alt_q(alt_q), .wave_q(wave_q), .stop_o(stop)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_q     <= '0;
      pri_q     <= '0;
      alt_lim_q <= '0;
    end else begin
      if (ctl_we) begin
        ctl_q.run  <= bus_wdata[B_RUN];
        ctl_q.dual <= bus_wdata[B_DUAL];
        ctl_q.cont <= bus_wdata[B_CONT];
        ctl_q.ext  <= bus_wdata[B_EXT];
      end else if (stop) begin
        ctl_q.run <= 1'b0;
      end
      if (bus_sel && bus_wr && bus_addr == A_PRI) pri_q     <= bus_wdata;
      if (bus_sel && bus_wr && bus_addr == A_ALT) alt_lim_q <= bus_wdata;
    end
  end

  always_comb begin
    case (bus_addr)
      A_CTL:   rd_mux = W'({alt_q, ctl_q.ext, ctl_q.cont, ctl_q.dual, ctl_q.run});
      A_CNT:   rd_mux = cnt_q;
      A_PRI:   rd_mux = pri_q;
      default: rd_mux = alt_lim_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)        bus_rdata <= '0;
    else if (rd_en) bus_rdata <= rd_mux;
  end

  assign wave_out = wave_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int W = 16
) (
  input logic         clk,
  input logic         rst,
  input logic         svc,
  input logic         run_q,
  input logic         dual_q,
  input logic         alt_q,
  input logic         wave_q,
  input logic         ctl_we,
  input logic         cnt_we,
  input logic [W-1:0] cnt_q
);
  p_slot_gap_r4: assert property (@(posedge clk) disable iff (rst)
    svc |=> !svc);

  p_count_on_slot_r4: assert property (@(posedge clk) disable iff (rst)
    (!$stable(cnt_q) && !$past(cnt_we)) |-> $past(svc));

  p_pulse_width_r5: assert property (@(posedge clk) disable iff (rst)
    (!dual_q && $past(!dual_q) && !wave_q) |=> wave_q);

  p_dual_level_r6: assert property (@(posedge clk) disable iff (rst)
    dual_q |-> (wave_q == !alt_q));

  p_oneshot_stop_r8: assert property (@(posedge clk) disable iff (rst)
    ($fell(run_q) && !$past(ctl_we)) |-> $past(svc));
endmodule

bind dl_event_timer tmr_checker #(.W(W)) i_chk (
  .clk(clk), .rst(rst), .svc(svc), .run_q(ctl_q.run), .dual_q(ctl_q.dual),
  .alt_q(alt_q), .wave_q(wave_q), .ctl_we(ctl_we), .cnt_we(cnt_we),
  .cnt_q(cnt_q)
);

// File: tb/test_dl_event_timer.sv
module test_dl_event_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_sel = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [15:0] bus_wdata = 16'd0;
  logic [15:0] bus_rdata;
  logic        ext_evt = 1'b0;
  logic        wave_out;

  int e = 0;
  int n_chk = 0;
  int n_bad = 0;

  dl_event_timer i_dl_event_timer (
    .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .ext_evt(ext_evt), .wave_out(wave_out)
  );

  always #5 clk = ~clk;

  always @(posedge clk) begin
    if (rst) e <= 0;
    else     e <= e + 1;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h (edge %0d)", req, act, exp, e);
    end
  endtask

  function automatic int nev(input int w, input int x);
    return (x / 4) - (w / 4);
  endfunction

  task automatic wr(input logic [1:0] a, input logic [15:0] d, output int w);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    w = e;
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    v = bus_rdata;
  endtask

  task automatic pre_slot();
    while (((e + 1) % 4) != 0) @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk(wave_out === 1'b1, "R1 wave", wave_out, 1);
    for (int a = 0; a < 4; a++) begin
      rd(a[1:0], v);
      chk(v === 16'd0, "R1 register", v, 0);
    end
  endtask

  task automatic t_regs();
    logic [15:0] v; int w;
    wr(2'd2, 16'h1234, w);
    wr(2'd3, 16'hBEEF, w);
    wr(2'd1, 16'h0042, w);
    wr(2'd0, 16'h001E, w);
    rd(2'd2, v); chk(v === 16'h1234, "R2 primary", v, 16'h1234);
    rd(2'd3, v); chk(v === 16'hBEEF, "R2 alternate", v, 16'hBEEF);
    rd(2'd1, v); chk(v === 16'h0042, "R2 count", v, 16'h0042);
    rd(2'd0, v); chk(v === 16'h000E, "R2 control flag read-only", v, 16'h000E);
    wr(2'd0, 16'h0000, w);
  endtask

  task automatic t_single();
    logic [15:0] v; int w; int w2; int j; bit expw;
    wr(2'd2, 16'd4, w);
    wr(2'd1, 16'd0, w);
    wr(2'd0, 16'h0005, w);
    for (int k = 0; k < 64; k++) begin
      @(negedge clk);
      j = nev(w, e);
      expw = !((e % 4 == 0) && (j > 0) && (j % 4 == 0));
      chk(wave_out === expw, "R5 single pulse", wave_out, expw);
    end
    wr(2'd0, 16'h0000, w2);
    rd(2'd1, v);
    chk(v === 16'(nev(w, w2) % 4), "R3 wrap count", v, nev(w, w2) % 4);
    rd(2'd1, v);
    chk(v === 16'(nev(w, w2) % 4), "R10 stopped count", v, nev(w, w2) % 4);
  endtask

  task automatic t_write_wins();
    logic [15:0] v; int w;
    wr(2'd2, 16'd1000, w);
    wr(2'd0, 16'h0005, w);
    idle(3);
    pre_slot();
    wr(2'd1, 16'h0100, w);
    wr(2'd0, 16'h0000, w);
    rd(2'd1, v);
    chk(v === 16'h0100, "R2 write over slot increment", v, 16'h0100);
  endtask

  task automatic t_oneshot_zero();
    logic [15:0] v; int w; int lows = 0;
    wr(2'd2, 16'd0, w);
    wr(2'd1, 16'hFFFE, w);
    wr(2'd0, 16'h0001, w);
    for (int k = 0; k < 30; k++) begin
      @(negedge clk);
      if (wave_out === 1'b0) lows++;
    end
    chk(lows == 1, "R3 limit zero one wrap", lows, 1);
    rd(2'd0, v); chk(v === 16'h0000, "R8 single one-shot stop", v, 0);
    rd(2'd1, v); chk(v === 16'h0000, "R3 limit zero count", v, 0);
  endtask

  task automatic t_dual();
    logic [15:0] v; int w; int j; bit alt; bit expw;
    wr(2'd2, 16'd3, w);
    wr(2'd3, 16'd2, w);
    wr(2'd1, 16'd0, w);
    wr(2'd0, 16'h0007, w);
    for (int k = 0; k < 80; k++) begin
      @(negedge clk);
      j = nev(w, e);
      expw = !((j % 5) >= 3);
      chk(wave_out === expw, "R6 dual level", wave_out, expw);
    end
    rd(2'd0, v);
    j = nev(w, e - 1);
    alt = (j % 5) >= 3;
    chk(v === (16'h0007 | (16'(alt) << 4)), "R6 alternate flag", v, 16'h0007 | (16'(alt) << 4));
    while ((nev(w, e) % 5) < 3 || ((e + 1) % 4) == 0) @(negedge clk);
    chk(wave_out === 1'b0, "R6 alternate active", wave_out, 0);
    wr(2'd0, 16'h0006, w);
    chk(wave_out === 1'b1, "R7 wave back to primary", wave_out, 1);
    rd(2'd0, v);
    chk(v === 16'h0006, "R7 flag cleared", v, 16'h0006);
  endtask

  task automatic t_dual_oneshot();
    logic [15:0] v; int w; int lows = 0;
    wr(2'd2, 16'd2, w);
    wr(2'd3, 16'd3, w);
    wr(2'd1, 16'd0, w);
    wr(2'd0, 16'h0003, w);
    for (int k = 0; k < 40; k++) begin
      @(negedge clk);
      if (wave_out === 1'b0) lows++;
    end
    chk(lows == 12, "R6 duty from limits", lows, 12);
    rd(2'd0, v); chk(v === 16'h0002, "R8 dual one-shot stop", v, 16'h0002);
    rd(2'd1, v); chk(v === 16'h0000, "R8 dual one-shot count", v, 0);
    chk(wave_out === 1'b1, "R8 dual one-shot wave", wave_out, 1);
  endtask

  task automatic t_stopped();
    logic [15:0] v; int w; int lows = 0;
    wr(2'd2, 16'd3, w);
    wr(2'd1, 16'd7, w);
    wr(2'd0, 16'h0004, w);
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (wave_out === 1'b0) lows++;
    end
    rd(2'd1, v); chk(v === 16'd7, "R10 run clear holds count", v, 7);
    chk(lows == 0, "R10 run clear wave", lows, 0);
  endtask

  task automatic t_ext();
    logic [15:0] v; int w; int lag; int lows;
    wr(2'd2, 16'd1, w);
    wr(2'd1, 16'd0, w);
    wr(2'd0, 16'h000D, w);
    idle(8);
    for (int off = 0; off < 4; off++) begin
      while ((e % 4) != off) @(negedge clk);
      ext_evt = 1'b1;
      lag = 0; lows = 0;
      for (int k = 1; k <= 10; k++) begin
        @(negedge clk);
        if (wave_out === 1'b0) begin
          lows++;
          if (lag == 0) lag = k;
        end
      end
      ext_evt = 1'b0;
      for (int k = 0; k < 8; k++) begin
        @(negedge clk);
        if (wave_out === 1'b0) lows++;
      end
      chk(lag >= 3 && lag <= 6, "R9 external lag", lag, 6);
      chk(lows == 1, "R9 one event per edge", lows, 1);
    end
    wr(2'd2, 16'd100, w);
    wr(2'd1, 16'd0, w);
    for (int p = 0; p < 10; p++) begin
      ext_evt = 1'b1; idle(4);
      ext_evt = 1'b0; idle(4);
    end
    idle(8);
    rd(2'd1, v); chk(v === 16'd10, "R9 external edge count", v, 10);
  endtask

  task automatic t_ext_stopped();
    logic [15:0] v; int w;
    wr(2'd1, 16'd0, w);
    wr(2'd0, 16'h0008, w);
    for (int p = 0; p < 3; p++) begin
      ext_evt = 1'b1; idle(4);
      ext_evt = 1'b0; idle(4);
    end
    idle(8);
    wr(2'd0, 16'h000D, w);
    idle(16);
    rd(2'd1, v); chk(v === 16'd0, "R10 edges while stopped discarded", v, 0);
    wr(2'd0, 16'h0000, w);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk + 1, n_bad);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_regs();
    t_single();
    t_write_wins();
    t_oneshot_zero();
    t_dual();
    t_dual_oneshot();
    t_stopped();
    t_ext();
    t_ext_stopped();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule